// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address onto a real address through a small set of block translation entries. It keeps two banks of entries, one for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words, an upper (tag) word and a lower (target) word. A lookup compares the address against every entry of the selected bank in parallel and picks the lowest-numbered entry that matches. One clock later it reports a hit flag, the index of that entry, the page-aligned real address and the read/write/execute permissions that the entry grants. The block does not raise faults. A downstream checker decides what to do with the permissions.

Software loads the entries through a single write port that selects the bank, the entry and the word. A per-request mode bit picks one of two entry layouts. The standard layout gates validity by privilege and takes a two-bit protection field from the lower word. The legacy layout keeps the valid bit and the length field in the lower word, and derives the permissions from a privilege-selected key together with a protection field in the upper word. In both layouts the block-length field widens the match region by clearing bits out of a compare mask.

Top module: `bat_xlate_match`

## Requirements
- R1: A request with `req_kind` = 2 (fetch) searches only the instruction bank. Kinds 0 (load), 1 (store) and 3 search only the data bank.
- R2: In the standard layout, upper bit 1 validates an entry for supervisor requests (`req_user`=0) and upper bit 0 validates it for user requests. An entry that is not valid for the request never hits.
- R3: The compare mask is 0xFFFE0000 with the block-length field cleared out of it. In the standard layout that field is upper bits 12:2, placed at bits 27:17. An entry hits when (ea & mask) equals the upper word's bits 31:17 with bits 16:0 zero.
- R4: On a hit, `rsp_raddr` is ((lower & mask) | (ea & ~mask)) with bits 11:0 forced to zero.
- R5: In the legacy layout (`req_legacy`=1), the valid bit is lower bit 6 and the length field is lower bits 5:0, placed at mask bits 22:17. The privilege bits of the upper word are ignored.
- R6: In the legacy layout, the key is upper bit 3 for supervisor requests and upper bit 2 for user requests. The protection field is upper bits 1:0. With key 0, field 3 gives read+execute and the other values give read+write+execute. With key 1, field 0 gives nothing, field 2 gives read+write+execute, and fields 1 and 3 give read+execute.
- R7: In the standard layout, the protection field is lower bits 1:0. Value 0 gives nothing, values 1 and 3 give read+execute, and value 2 gives read+write+execute. `rsp_perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R8: When several entries hit, the lowest index wins, and `rsp_idx` reports that index.
- R9: On a miss, `rsp_hit`, `rsp_raddr` and `rsp_perm` are all zero.
- R10: `rsp_valid` is `req_valid` delayed by one clock. While no request is presented, the other outputs hold their values.
- R11: A write stores `wr_data` into the upper word (`wr_upper`=1) or lower word of entry `wr_idx` in the instruction bank (`wr_instr`=1) or the data bank. A lookup in the same cycle sees the contents from before the write.
- R12: Synchronous reset clears every entry and every output, so every lookup misses until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_instr | input | 1 | 1 selects the instruction bank, 0 the data bank |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_idx | input | IDX_W | Entry index to write |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 user privilege, 0 supervisor |
| req_legacy | input | 1 | 1 selects the legacy entry layout |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | IDX_W | Index of the winning entry |
| rsp_raddr | output | 32 | Page-aligned real address |
| rsp_perm | output | 3 | Granted permissions {execute, write, read} |

## Verification
The bench targets overlapping entries whose privilege bits differ. A broken priority or privilege gate would return the wrong index and the wrong target address. It uses a maximal length field that opens a whole 256 MB region and an address one bit outside a widened block. A mask built with the wrong shift would hit where it should miss, or miss where it should hit. Legacy lookups run against entries whose standard-layout valid bits are set, and the key-selected permission table is driven through its extreme values. A design that read the wrong word or swapped the keys would grant the wrong rights. A write and a lookup to the same entry in one cycle show whether the read sees old contents, and idle cycles show whether the outputs hold.

// File: rtl/bat_pkg.sv
package bat_pkg;

  localparam int WORD_W    = 32;
  localparam int TAG_LSB   = 17;
  localparam logic [WORD_W-1:0] TAG_FIELD = 32'hFFFE_0000;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
  } perm_t;

  localparam perm_t PERM_NONE = '{ex: 1'b0, wr: 1'b0, rd: 1'b0};
  localparam perm_t PERM_RX   = '{ex: 1'b1, wr: 1'b0, rd: 1'b1};
  localparam perm_t PERM_RWX  = '{ex: 1'b1, wr: 1'b1, rd: 1'b1};

  function automatic perm_t std_perm(input logic [1:0] prot);
    case (prot)
      2'd0:    std_perm = PERM_NONE;
      2'd2:    std_perm = PERM_RWX;
      default: std_perm = PERM_RX;
    endcase
  endfunction

  function automatic perm_t key_perm(input logic key, input logic [1:0] prot);
    if (!key) begin
      key_perm = (prot == 2'd3) ? PERM_RX : PERM_RWX;
    end else begin
      case (prot)
        2'd0:    key_perm = PERM_NONE;
        2'd2:    key_perm = PERM_RWX;
        default: key_perm = PERM_RX;
      endcase
    end
  endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_upper,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  output logic [31:0]       upper_q [DEPTH],
  output logic [31:0]       lower_q [DEPTH]
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        upper_q[e] <= '0;
        lower_q[e] <= '0;
      end else if (sel) begin
        if (wr_upper) upper_q[e] <= wr_data;
        else          lower_q[e] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
  import bat_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [31:0] upper,
  input  logic [31:0] lower,
  input  logic [31:0] ea,
  input  logic        user,
  input  logic        legacy,
  output logic        hit,
  output logic [31:0] raddr,
  output perm_t       perm
);

  logic        valid;
  logic [31:0] len_bits;
  logic [31:0] mask;
  logic [31:0] tag;
  logic [31:0] joined;

  always_comb begin
    if (legacy) begin
      valid    = lower[6];
      len_bits = {9'd0, lower[5:0], 17'd0};
    end else begin
      valid    = user ? upper[0] : upper[1];
      len_bits = {4'd0, upper[12:2], 17'd0};
    end
    tag    = upper & TAG_FIELD;
    mask   = valid ? (TAG_FIELD & ~len_bits) : '0;
    hit    = valid && ((ea & mask) == tag);
    joined = (lower & mask) | (ea & ~mask);
    raddr  = {joined[31:PAGE_BITS], {PAGE_BITS{1'b0}}};
    if (legacy) perm = key_perm(user ? upper[2] : upper[3], upper[1:0]);
    else        perm = std_perm(lower[1:0]);
  end

endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0] hits,
  output logic [DEPTH-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx   = '0;
    any   = 1'b0;
    grant = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
    if (any) grant[idx] = 1'b1;
  end

  // R8: the winner is one of the hits, is the only one, and no lower hit is skipped
  always_comb begin
    a_r8_first_hit : assert ((grant & ~hits) == '0 && $onehot0(grant) && (any == (|hits))
                             && ((hits & (grant - 1'b1)) == '0 || !any));
  end

endmodule

// File: rtl/bat_xlate_match.sv
module bat_xlate_match
  import bat_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_instr,
  input  logic             wr_upper,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic             req_legacy,
  input  logic [31:0]      req_ea,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [31:0]      rsp_raddr,
  output logic [2:0]       rsp_perm
);

  localparam int NSIDE = 2;

  logic [31:0] bank_up [NSIDE][DEPTH];
  logic [31:0] bank_lo [NSIDE][DEPTH];

  for (genvar s = 0; s < NSIDE; s++) begin : g_bank
    logic [31:0] up_w [DEPTH];
    logic [31:0] lo_w [DEPTH];
    bat_regfile #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_rf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en && (wr_instr == (s == 1))),
      .wr_upper (wr_upper),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .upper_q  (up_w),
      .lower_q  (lo_w)
    );
    for (genvar e = 0; e < DEPTH; e++) begin : g_cp
      assign bank_up[s][e] = up_w[e];
      assign bank_lo[s][e] = lo_w[e];
    end
  end

  logic             is_fetch;
  logic [DEPTH-1:0] hits;
  logic [DEPTH-1:0] grant;
  logic [IDX_W-1:0] win_idx;
  logic             win_any;
  logic [31:0]      ent_ra   [DEPTH];
  perm_t            ent_perm [DEPTH];

  assign is_fetch = (req_kind == ACC_FETCH);

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    bat_entry_cmp #(.PAGE_BITS(PAGE_BITS)) i_cmp (
      .upper  (is_fetch ? bank_up[1][e] : bank_up[0][e]),
      .lower  (is_fetch ? bank_lo[1][e] : bank_lo[0][e]),
      .ea     (req_ea),
      .user   (req_user),
      .legacy (req_legacy),
      .hit    (hits[e]),
      .raddr  (ent_ra[e]),
      .perm   (ent_perm[e])
    );
  end

  bat_prio_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_prio (
    .hits  (hits),
    .grant (grant),
    .idx   (win_idx),
    .any   (win_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_raddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= win_any;
        rsp_idx   <= win_idx;
        rsp_raddr <= win_any ? ent_ra[win_idx] : '0;
        rsp_perm  <= win_any ? ent_perm[win_idx] : '0;
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r10_valid_delay : assert property (@(posedge clk) disable iff (rst)
    armed |-> (rsp_valid == $past(req_valid)));

  a_r10_hold_idle : assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(req_valid)) |-> ($stable(rsp_raddr) && $stable(rsp_hit) && $stable(rsp_perm)));

  a_r9_miss_zero : assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_raddr == '0 && rsp_perm == '0));

  a_r4_page_aligned : assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_raddr[PAGE_BITS-1:0] == '0));

  a_r7_write_needs_read : assert property (@(posedge clk) disable iff (rst)
    rsp_perm[1] |-> (rsp_perm[0] && rsp_perm[2]));

endmodule

// File: tb/test_bat_xlate_match.sv
module test_bat_xlate_match;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_instr = 1'b0, wr_upper = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_legacy = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_ea = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_idx;
  logic [31:0] rsp_raddr;
  logic [2:0]  rsp_perm;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bat_xlate_match i_bat_xlate_match (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_instr(wr_instr), .wr_upper(wr_upper),
    .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid), .req_kind(req_kind),
    .req_user(req_user), .req_legacy(req_legacy), .req_ea(req_ea),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  kind;
    logic        user;
    logic        leg;
    logic [31:0] ea;
    logic        hit;
    logic [1:0]  idx;
    logic [31:0] ra;
    logic [2:0]  perm;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  2'd0, 1'b0, 1'b0, 32'h1000_1234, 1'b1, 2'd0, 32'h8000_1000, 3'b111}, // R8 R2 R4 R7
    '{8'd2,  2'd0, 1'b1, 1'b0, 32'h1000_1234, 1'b1, 2'd1, 32'h9000_1000, 3'b101}, // R2 user skips entry 0
    '{8'd3,  2'd1, 1'b0, 1'b0, 32'h1006_5678, 1'b1, 2'd1, 32'h9006_5000, 3'b101}, // R3 widened block
    '{8'd3,  2'd0, 1'b0, 1'b0, 32'h1008_0000, 1'b0, 2'd0, 32'h0,         3'b000}, // R3 one bit outside
    '{8'd2,  2'd0, 1'b0, 1'b0, 32'h2000_0000, 1'b0, 2'd0, 32'h0,         3'b000}, // R2 user-only entry
    '{8'd7,  2'd0, 1'b1, 1'b0, 32'h2000_0010, 1'b1, 2'd2, 32'hA000_0000, 3'b000}, // R7 field 0
    '{8'd4,  2'd1, 1'b1, 1'b0, 32'h3ABC_DEF0, 1'b1, 2'd3, 32'h4ABC_D000, 3'b101}, // R4 R3 full length
    '{8'd1,  2'd2, 1'b0, 1'b0, 32'h1000_1234, 1'b1, 2'd0, 32'h5000_1000, 3'b111}, // R1 fetch bank
    '{8'd1,  2'd2, 1'b0, 1'b0, 32'h3000_0000, 1'b0, 2'd0, 32'h0,         3'b000}, // R1 data entry unseen
    '{8'd1,  2'd3, 1'b1, 1'b0, 32'h1000_1234, 1'b1, 2'd1, 32'h9000_1000, 3'b101}, // R1 kind 3 is data
    '{8'd6,  2'd2, 1'b0, 1'b1, 32'h6002_3456, 1'b1, 2'd1, 32'h7002_3000, 3'b111}, // R6 R5 key0 field1
    '{8'd6,  2'd2, 1'b1, 1'b1, 32'h6002_3456, 1'b1, 2'd1, 32'h7002_3000, 3'b101}, // R6 key1 field1
    '{8'd5,  2'd2, 1'b0, 1'b1, 32'h6004_0000, 1'b0, 2'd0, 32'h0,         3'b000}, // R5 legacy length
    '{8'd5,  2'd0, 1'b0, 1'b1, 32'h1000_1234, 1'b0, 2'd0, 32'h0,         3'b000}, // R5 valid from lower
    '{8'd6,  2'd2, 1'b0, 1'b1, 32'h6800_1000, 1'b1, 2'd2, 32'h7800_1000, 3'b000}  // R6 key1 field0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ins, input logic [1:0] idx, input logic up, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_instr = ins; wr_idx = idx; wr_upper = up; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] k, input logic u, input logic lg, input logic [31:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_user = u; req_legacy = lg; req_ea = ea;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R12 rsp_raddr after reset", rsp_raddr, 32'd0);
    look(2'd0, 1'b0, 1'b0, 32'h0000_0000);
    chk("R12 empty bank misses", 32'(rsp_hit), 32'd0);
    chk("R10 rsp_valid one cycle later", 32'(rsp_valid), 32'd1);

    // R11: program the banks
    wr(1'b0, 2'd0, 1'b1, 32'h1000_0002); wr(1'b0, 2'd0, 1'b0, 32'h8000_0002);
    wr(1'b0, 2'd1, 1'b1, 32'h1000_000F); wr(1'b0, 2'd1, 1'b0, 32'h9000_0001);
    wr(1'b0, 2'd2, 1'b1, 32'h2000_0001); wr(1'b0, 2'd2, 1'b0, 32'hA000_0000);
    wr(1'b0, 2'd3, 1'b1, 32'h3000_1FFF); wr(1'b0, 2'd3, 1'b0, 32'h4000_0003);
    wr(1'b1, 2'd0, 1'b1, 32'h1000_0003); wr(1'b1, 2'd0, 1'b0, 32'h5000_0002);
    wr(1'b1, 2'd1, 1'b1, 32'h6000_0005); wr(1'b1, 2'd1, 1'b0, 32'h7000_0041);
    wr(1'b1, 2'd2, 1'b1, 32'h6800_0008); wr(1'b1, 2'd2, 1'b0, 32'h7800_0040);

    for (int v = 0; v < NV; v++) begin
      look(VECS[v].kind, VECS[v].user, VECS[v].leg, VECS[v].ea);
      total++;
      if (rsp_hit !== VECS[v].hit || rsp_raddr !== VECS[v].ra || rsp_perm !== VECS[v].perm ||
          (VECS[v].hit && rsp_idx !== VECS[v].idx)) begin
        bad++;
        $display("FAIL R%0d vector %0d actual hit=%b idx=%0d ra=%h perm=%b expected hit=%b idx=%0d ra=%h perm=%b",
                 VECS[v].req, v, rsp_hit, rsp_idx, rsp_raddr, rsp_perm,
                 VECS[v].hit, VECS[v].idx, VECS[v].ra, VECS[v].perm);
      end
    end

    // R6: user key 0 with field 0 grants everything
    look(2'd2, 1'b1, 1'b1, 32'h6800_1000);
    chk("R6 key0 field0 perm", 32'(rsp_perm), 32'b111);

    // R10: outputs hold while idle
    @(negedge clk);
    chk("R10 rsp_valid low when idle", 32'(rsp_valid), 32'd0);
    chk("R10 rsp_perm held", 32'(rsp_perm), 32'b111);
    chk("R10 rsp_raddr held", rsp_raddr, 32'h7800_1000);

    // R11: lookup in the write cycle sees old contents
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_user = 1'b1; req_legacy = 1'b0; req_ea = 32'h2000_0010;
    wr_en = 1'b1; wr_instr = 1'b0; wr_idx = 2'd2; wr_upper = 1'b1; wr_data = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk("R11 same-cycle lookup sees old entry", 32'(rsp_hit), 32'd1);
    look(2'd0, 1'b1, 1'b0, 32'h2000_0010);
    chk("R11 cleared entry now misses", 32'(rsp_hit), 32'd0);
    chk("R9 miss raddr zero", rsp_raddr, 32'd0);

    // R12: reset mid-run empties the banks
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R12 outputs cleared by reset", 32'(rsp_hit), 32'd0);
    look(2'd0, 1'b0, 1'b0, 32'h1000_1234);
    chk("R12 entries cleared by reset", 32'(rsp_hit), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule